// File: doc/BRIEF.md
# Interrupt Status Summary Controller

This block keeps the pending-event status word and the interrupt enable word of a network controller, and turns them into one level-sensitive interrupt line. Single-cycle event pulses from the transmit, receive and link logic set individual status bits. Software uses one register port. A write to the status word clears every event bit written with a one. A write to the enable word replaces that word. Either word can be read back on the same port.

Events fall into two groups, routine and error. Each group has its own summary bit in the status word. A summary bit is derived only from events that are both pending and enabled. The interrupt line is registered: it rises when an enabled summary bit is set, and it changes one clock after the status or enable word changes.

The status word also holds two 3-bit process-state fields, which are loaded through a separate strobe. Status clears never touch them. A software-reset pulse, which comes from a neighbouring mode register, returns both words to their reset values. All ports are plain control and status signals. There is no handshake and no back-pressure: an event pulse or a write is taken on the clock edge where it is present.

Top module: `isr_summary_ctrl`

## Requirements
- R1: After reset, the status word reads 0xF0000000, the enable word reads 0xF3FE0000, and `irq_o` is 0.
- R2: A one on an event bit of `evt_i` sets that status bit at the next clock edge. The event bits are 0–14, 26 and 27. A one on any other bit of `evt_i` changes nothing.
- R3: Writing the status word (`wr_sel_i`=0) clears each event bit where `wr_data_i` is 1 and leaves bits written with 0 unchanged. Bits 31:28 always read 1.
- R4: If an event pulse and a status clear reach the same bit on the same edge, the bit ends up set.
- R5: Status bit 16, the routine summary, reads 1 exactly when some bit among 0, 2, 6, 11 and 14 is set in both status and enable.
- R6: Status bit 15, the error summary, reads 1 exactly when some bit among 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26 and 27 is set in both status and enable.
- R7: `irq_o` becomes 1 one cycle after status AND enable has a one in bit 15 or bit 16, and becomes 0 one cycle after it has none.
- R8: Writing the enable word (`wr_sel_i`=1) stores all 32 bits of `wr_data_i`, and they read back unchanged with `rd_sel_i`=1.
- R9: A `soft_rst_i` pulse restores both reset values at the next edge. It overrides any event, write or load on that edge, and `irq_o` is 0 one cycle later.
- R10: `ps_we_i` loads `ps_i` into status bits 22:17. Status writes leave these bits unchanged, even when the data is all ones.
- R11: Writing a one to a summary bit does not clear it while an enabled pending event still drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, one bit per status position |
| soft_rst_i | input | 1 | Software-reset pulse from the mode register |
| ps_we_i | input | 1 | Load strobe for the process-state fields |
| ps_i | input | 6 | Process-state value for bits 22:17 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 for status (write-one-to-clear), 1 for enable |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read select: 0 for status, 1 for enable |
| rd_data_o | output | 32 | Selected word, with live summary bits |
| norm_sum_o | output | 1 | Routine summary bit |
| err_sum_o | output | 1 | Error summary bit |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest situation to reach from the ports is a clash on a single edge: an event pulse and a software clear on the same bit, or a software reset together with events, writes and loads. Directed steps place these on one edge deliberately. A further step writes a one to a summary bit while its cause is still pending and enabled. Sparse random event patterns, mixed with random writes, enable masks and occasional resets, then move the two summaries and the interrupt line through every combination of their states.

// File: rtl/isr_pkg.sv
`timescale 1ns/1ps
package isr_pkg;
  localparam int DW     = 32;
  localparam int PS_LSB = 17;
  localparam int PS_W   = 6;
  localparam int NSUM_BIT = 16;
  localparam int ESUM_BIT = 15;

  localparam logic [DW-1:0] NORM_MASK = 32'h0000_4845;
  localparam logic [DW-1:0] ERR_MASK  = 32'h0C00_37BA;
  localparam logic [DW-1:0] EVT_MASK  = NORM_MASK | ERR_MASK;
  localparam logic [DW-1:0] SUM_MASK  = (32'h1 << NSUM_BIT) | (32'h1 << ESUM_BIT);
  localparam logic [DW-1:0] PS_MASK   = ((32'h1 << PS_W) - 32'h1) << PS_LSB;
  localparam logic [DW-1:0] STAT_RST  = 32'hF000_0000;
  localparam logic [DW-1:0] EN_RST    = 32'hF3FE_0000;

  typedef enum logic {SEL_STAT = 1'b0, SEL_EN = 1'b1} reg_sel_e;
endpackage

// File: rtl/isr_status_bank.sv
`timescale 1ns/1ps
module isr_status_bank #(
  parameter int              W        = 32,
  parameter logic [W-1:0]    EV_MASK  = '0,
  parameter logic [W-1:0]    RST_VAL  = '0,
  parameter int              F_LSB    = 17,
  parameter int              F_W      = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic [W-1:0]   set_vec,
  input  logic [W-1:0]   clr_vec,
  input  logic           fld_we,
  input  logic [F_W-1:0] fld_val,
  output logic [W-1:0]   stat_q
);
  localparam int F_MSB = F_LSB + F_W - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic bit_q;
    if (EV_MASK[b]) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bit_q <= RST_VAL[b];
        else if (soft_rst)   bit_q <= RST_VAL[b];
        else if (set_vec[b]) bit_q <= 1'b1;
        else if (clr_vec[b]) bit_q <= 1'b0;
      end
    end else if (b >= F_LSB && b <= F_MSB) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bit_q <= RST_VAL[b];
        else if (soft_rst) bit_q <= RST_VAL[b];
        else if (fld_we)   bit_q <= fld_val[b-F_LSB];
      end
    end else begin : g_const
      assign bit_q = RST_VAL[b];
    end
    assign stat_q[b] = bit_q;
  end
endmodule

// File: rtl/isr_enable_reg.sv
`timescale 1ns/1ps
module isr_enable_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= RST_VAL;
    else if (soft_rst) en_q <= RST_VAL;
    else if (we)       en_q <= wdata;
  end
endmodule

// File: rtl/isr_summary.sv
`timescale 1ns/1ps
module isr_summary #(
  parameter int           W      = 32,
  parameter logic [W-1:0] N_MASK = '0,
  parameter logic [W-1:0] E_MASK = '0,
  parameter int           N_BIT  = 16,
  parameter int           E_BIT  = 15
) (
  input  logic [W-1:0] stat_q,
  input  logic [W-1:0] en_q,
  output logic [W-1:0] view,
  output logic         norm_sum,
  output logic         err_sum,
  output logic         irq_d
);
  logic [W-1:0] live;
  logic [W-1:0] sum_sel;

  always_comb begin
    live     = stat_q & en_q;
    norm_sum = |(live & N_MASK);
    err_sum  = |(live & E_MASK);
    view     = stat_q;
    view[N_BIT] = norm_sum;
    view[E_BIT] = err_sum;
    sum_sel  = '0;
    sum_sel[N_BIT] = 1'b1;
    sum_sel[E_BIT] = 1'b1;
    irq_d    = |(view & en_q & sum_sel);
  end
endmodule

// File: rtl/isr_irq_reg.sv
`timescale 1ns/1ps
module isr_irq_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_d,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/isr_summary_ctrl.sv
`timescale 1ns/1ps
module isr_summary_ctrl
  import isr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  evt_i,
  input  logic           soft_rst_i,
  input  logic           ps_we_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic           wr_en_i,
  input  logic           wr_sel_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           rd_sel_i,
  output logic [DW-1:0]  rd_data_o,
  output logic           norm_sum_o,
  output logic           err_sum_o,
  output logic           irq_o
);
  logic [DW-1:0] stat_q, en_q, view, set_vec, clr_vec;
  logic          en_we, irq_d;

  assign set_vec = evt_i & EVT_MASK;
  assign clr_vec = (wr_en_i && reg_sel_e'(wr_sel_i) == SEL_STAT) ? (wr_data_i & EVT_MASK) : '0;
  assign en_we   = wr_en_i && reg_sel_e'(wr_sel_i) == SEL_EN;

  isr_status_bank #(.W(DW), .EV_MASK(EVT_MASK), .RST_VAL(STAT_RST),
                    .F_LSB(PS_LSB), .F_W(PS_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .set_vec(set_vec),
    .clr_vec(clr_vec), .fld_we(ps_we_i), .fld_val(ps_i), .stat_q(stat_q));

  isr_enable_reg #(.W(DW), .RST_VAL(EN_RST)) u_en (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .we(en_we),
    .wdata(wr_data_i), .en_q(en_q));

  isr_summary #(.W(DW), .N_MASK(NORM_MASK), .E_MASK(ERR_MASK),
                .N_BIT(NSUM_BIT), .E_BIT(ESUM_BIT)) u_sum (
    .stat_q(stat_q), .en_q(en_q), .view(view), .norm_sum(norm_sum_o),
    .err_sum(err_sum_o), .irq_d(irq_d));

  isr_irq_reg u_irq (.clk(clk), .rst_n(rst_n), .irq_d(irq_d), .irq_q(irq_o));

  assign rd_data_o = (reg_sel_e'(rd_sel_i) == SEL_EN) ? en_q : view;
endmodule

// File: rtl/isr_summary_ctrl_chk.sv
`timescale 1ns/1ps
module isr_summary_ctrl_chk
  import isr_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [DW-1:0]  evt_i,
  input logic           soft_rst_i,
  input logic           ps_we_i,
  input logic           wr_en_i,
  input logic           wr_sel_i,
  input logic [DW-1:0]  wr_data_i,
  input logic [DW-1:0]  stat_q,
  input logic [DW-1:0]  en_q,
  input logic [DW-1:0]  view,
  input logic           irq_o
);
  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst_i && |(evt_i & EVT_MASK)) |=>
      ((stat_q & $past(evt_i & EVT_MASK)) == $past(evt_i & EVT_MASK)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst_i && wr_en_i && !wr_sel_i && (evt_i & EVT_MASK) == '0) |=>
      ((stat_q & $past(wr_data_i & EVT_MASK)) == '0));

  p_fixed_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[31:28] == 4'hF);

  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq_o == $past(|(view & en_q & SUM_MASK))));

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (stat_q == STAT_RST && en_q == EN_RST));

  p_field_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ps_we_i && !soft_rst_i) |=> $stable(stat_q[PS_LSB+PS_W-1:PS_LSB]));

  p_enable_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst_i && wr_en_i && wr_sel_i) |=> (en_q == $past(wr_data_i)));
endmodule

bind isr_summary_ctrl isr_summary_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .soft_rst_i(soft_rst_i),
  .ps_we_i(ps_we_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .stat_q(stat_q), .en_q(en_q), .view(view),
  .irq_o(irq_o));

// File: tb/isr_summary_ctrl_test.sv
`timescale 1ns/1ps
module isr_summary_ctrl_test;
  import isr_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] evt = '0, wdata = '0;
  logic sr = 1'b0, ps_we = 1'b0, wen = 1'b0, wsel = 1'b0, rsel = 1'b0;
  logic [5:0] ps = '0;
  logic [31:0] rdata;
  logic nsum, esum, irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] m_stat, m_en;
  logic m_irq;

  always #2.5 clk = ~clk;

  isr_summary_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .soft_rst_i(sr), .ps_we_i(ps_we),
    .ps_i(ps), .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wdata),
    .rd_sel_i(rsel), .rd_data_o(rdata), .norm_sum_o(nsum), .err_sum_o(esum),
    .irq_o(irq));

  function automatic logic [31:0] exp_view(logic [31:0] s, logic [31:0] e);
    logic [31:0] v;
    v = s & ~SUM_MASK;
    if (|(v & e & NORM_MASK)) v[16] = 1'b1;
    if (|(v & e & ERR_MASK))  v[15] = 1'b1;
    return v;
  endfunction

  function automatic logic exp_irq(logic [31:0] s, logic [31:0] e);
    return |(exp_view(s, e) & e & SUM_MASK);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    v = exp_view(m_stat, m_en);
    rsel = 1'b0; #0.5;
    check(tag, "status", rdata, v);
    check(tag, "norm_sum", {31'b0, nsum}, {31'b0, v[16]});
    check(tag, "err_sum", {31'b0, esum}, {31'b0, v[15]});
    rsel = 1'b1; #0.5;
    check(tag, "enable", rdata, m_en);
    check(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic cycle(string tag, logic [31:0] e, logic we, logic sel,
                       logic [31:0] d, logic s, logic pw, logic [5:0] pv);
    logic [31:0] clr;
    evt = e; wen = we; wsel = sel; wdata = d; sr = s; ps_we = pw; ps = pv;
    @(posedge clk);
    m_irq = exp_irq(m_stat, m_en);
    if (s) begin
      m_stat = STAT_RST; m_en = EN_RST;
    end else begin
      clr = (we && !sel) ? (d & EVT_MASK) : '0;
      m_stat = (m_stat & ~clr) | (e & EVT_MASK);
      if (pw) m_stat[22:17] = pv;
      if (we && sel) m_en = d;
    end
    @(negedge clk);
    evt = '0; wen = 1'b0; sr = 1'b0; ps_we = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    m_stat = STAT_RST; m_en = EN_RST; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    cycle("R8", '0, 1, 1, NORM_MASK | ERR_MASK | SUM_MASK, 0, 0, '0);
    cycle("R2", 32'h1, 0, 0, '0, 0, 0, '0);
    cycle("R5", '0, 0, 0, '0, 0, 0, '0);
    cycle("R7", '0, 0, 0, '0, 0, 0, '0);
    cycle("R4", 32'h1, 1, 0, 32'h1, 0, 0, '0);
    cycle("R3", '0, 1, 0, 32'hF000_0001, 0, 0, '0);
    cycle("R7", '0, 0, 0, '0, 0, 0, '0);
    cycle("R11", 32'h40, 0, 0, '0, 0, 0, '0);
    cycle("R11", '0, 1, 0, 32'h0001_0000, 0, 0, '0);
    cycle("R3", '0, 1, 0, 32'h40, 0, 0, '0);
    cycle("R6", 32'h2000, 0, 0, '0, 0, 0, '0);
    cycle("R6", '0, 1, 1, SUM_MASK, 0, 0, '0);
    cycle("R2", 32'hF07F_8000, 0, 0, '0, 0, 0, '0);
    cycle("R10", '0, 0, 0, '0, 0, 1, 6'h2A);
    cycle("R10", '0, 1, 0, 32'hFFFF_FFFF, 0, 0, '0);
    cycle("R8", '0, 1, 1, 32'hFFFF_FFFF, 0, 0, '0);
    cycle("R7", 32'h0C00_0001, 0, 0, '0, 0, 0, '0);
    cycle("R7", '0, 0, 0, '0, 0, 0, '0);
    cycle("R9", 32'h0000_0810, 1, 1, 32'h1234_5678, 1, 1, 6'h15);
    cycle("R9", '0, 0, 0, '0, 0, 0, '0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] e, d;
      logic we, sl, s, pw;
      e  = $urandom & $urandom & $urandom;
      d  = $urandom;
      we = ($urandom % 4) == 0;
      sl = $urandom % 2;
      s  = ($urandom % 64) == 0;
      pw = ($urandom % 8) == 0;
      cycle("R7", e, we, sl, d, s, pw, 6'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule